// File: doc/BRIEF.md
# SD Card Clock and Strobe Generator

This block derives the clock sent to an SD or eMMC card from the system clock, which is nominally 100 MHz. An integer divider sets the card clock rate. The fastest setting is 50 MHz and the slowest of interest is 100 kHz. A mode flag picks single-edge (SDR) or double-edge (DDR) data timing. For either mode the block emits one-cycle launch and sample strobes, which the command and data shifters use to move bits.

The block also turns the value and drive request of each card line into pad controls. It can drive a line push-pull or open-drain, and this choice may change at any time while the block runs. A stop input parks the card clock low between transfers and silences every strobe. A new divider value waits for the next card clock period, so the card never sees a shortened pulse.

Top module: `sd_clk_gen`

## Requirements
- R1: While `rst_n` is low, and after the first system clock edge with reset applied, `card_clk`, `launch_stb`, `sample_stb` and `stb_on_rise` are all 0.
- R2: With divider value N on `cfg_div`, `card_clk` has a period of exactly 2×(N+1) system cycles. Its high half is N+1 cycles. N=0 gives half the system rate and N=499 gives a 1000-cycle period.
- R3: In SDR mode (`cfg_ddr`=0) there is one `launch_stb` pulse per card period, in the cycle in which `card_clk` first reads 0. There is one `sample_stb` pulse per period, in the cycle in which `card_clk` first reads 1. The two strobes never occur together.
- R4: In DDR mode (`cfg_ddr`=1), `launch_stb` and `sample_stb` both pulse in the first cycle after each card clock edge, rising and falling. `stb_on_rise` is 1 with the pulses that follow a rising edge and 0 with those that follow a falling edge.
- R5: The divider value is captured only when `card_clk` rises. A change to `cfg_div` in the middle of a period leaves the length of that period unchanged, and the new value governs the next full period.
- R6: While `clk_stop` is 1, no strobe is produced. If `card_clk` is low it stays low. If it is high, it finishes its high half and then stays low.
- R7: When reset or `clk_stop` is released with divider N, `card_clk` first reads 1 after exactly N+1 system clock edges. The value of `cfg_div` present during the stop is the one used.
- R8: In push-pull mode (`cfg_odrain`=0), each pad output equals the line value and each pad enable equals the line's drive request, with no delay.
- R9: In open-drain mode (`cfg_odrain`=1), each pad output is 0 and each pad enable equals the drive request AND the inverted line value. A line requested high is therefore released, never driven. The mode switch acts with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, nominal 100 MHz |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_div | input | DIV_W | Divider value N; card period is 2×(N+1) cycles |
| cfg_ddr | input | 1 | 1 = DDR strobe timing, 0 = SDR |
| cfg_odrain | input | 1 | 1 = open-drain line drive, 0 = push-pull |
| clk_stop | input | 1 | Park card clock low and suppress strobes |
| cmd_val | input | 1 | Value to place on the command line |
| cmd_req | input | 1 | Command line drive request |
| dat_val | input | DAT_W | Values to place on the data lines |
| dat_req | input | DAT_W | Data line drive requests |
| card_clk | output | 1 | Clock to the card |
| launch_stb | output | 1 | One-cycle strobe: shifters present the next bit |
| sample_stb | output | 1 | One-cycle strobe: shifters capture incoming bit |
| stb_on_rise | output | 1 | Strobes in this cycle follow a rising card clock edge |
| cmd_pad_o | output | 1 | Command pad output value |
| cmd_pad_oe | output | 1 | Command pad output enable |
| dat_pad_o | output | DAT_W | Data pad output values |
| dat_pad_oe | output | DAT_W | Data pad output enables |

## Verification
The bench measures card periods and half periods at the N=0 extreme, at middle settings and at the 100 kHz setting. A counter that reloads one count too early or too late shows up as a period off by two. The bench rewrites the divider in the middle of a high half. A design that loads the value at once would produce a short or long period there instead of finishing the old one. The bench asserts the stop while the clock is high and again while it is low, then releases it after changing the divider. A design that chopped the high pulse, leaked a strobe, or ignored the divider value written during the stop would miss the expected fall time or the count of N+1 edges before the first rise. Open-drain drive is checked over every value and request combination. A design that drives a 1 actively would be caught with its enable set.

// File: rtl/sd_clk_pkg.sv
// Package: shared types for the card clock generator.
// Assumes: nothing beyond IEEE 1800-2017.
package sd_clk_pkg;

    // Kind of card clock transition scheduled for the next system edge.
    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2
    } clk_edge_e;

endpackage

// File: rtl/clk_div_core.sv
// Module: clk_div_core
// Produces the card clock by counting system cycles in each half period.
// It schedules each transition and reports it combinationally to the strobe
// logic. The divider value is captured at a rising edge, or at any time
// while parked, so each full period uses a single value.
// Assumes: synchronous active-low reset; cfg_div may change at any time.
module clk_div_core
    import sd_clk_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             stop,
    output logic             card_clk,
    output clk_edge_e        edge_nxt
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_q;
    logic             clk_q;
    logic             parked;
    logic             at_end;

    // Decode the parked state and the end of the current half period.
    always_comb begin
        parked = stop && !clk_q;
        at_end = (cnt == div_q);
    end

    // Announce which transition, if any, the next edge will make.
    always_comb begin
        edge_nxt = EDGE_NONE;
        if (!parked && at_end) begin
            edge_nxt = clk_q ? EDGE_FALL : EDGE_RISE;
        end
    end

    // Half-period counter, card clock level and divider capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            clk_q <= 1'b0;
            div_q <= cfg_div;
        end else if (parked) begin
            cnt   <= '0;
            div_q <= cfg_div;
        end else if (at_end) begin
            cnt   <= '0;
            clk_q <= !clk_q;
            if (!clk_q) begin
                div_q <= cfg_div;
            end
        end else begin
            cnt <= cnt + ONE;
        end
    end

    assign card_clk = clk_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= div_q);                                                    // R2
    AST_PARK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stop) && !$past(clk_q)) |-> !clk_q);                       // R6
    AST_DIV_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_q && $past(clk_q)) |-> $stable(div_q));                      // R5

endmodule

// File: rtl/clk_strobe_gen.sv
// Module: clk_strobe_gen
// Turns the scheduled card clock transition into registered launch and
// sample strobes. They appear in the same cycle in which the card clock
// shows its new level. SDR uses one strobe per edge; DDR uses both on
// every edge.
// Assumes: edge_nxt comes from clk_div_core with the same clock and reset.
module clk_strobe_gen
    import sd_clk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  clk_edge_e edge_nxt,
    input  logic      ddr,
    input  logic      stop,
    output logic      launch,
    output logic      sample,
    output logic      on_rise
);

    logic is_rise;
    logic is_fall;

    // Qualify the transition with the stop request.
    always_comb begin
        is_rise = (edge_nxt == EDGE_RISE) && !stop;
        is_fall = (edge_nxt == EDGE_FALL) && !stop;
    end

    // Register the strobes so that they line up with the card clock register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            launch  <= 1'b0;
            sample  <= 1'b0;
            on_rise <= 1'b0;
        end else begin
            launch  <= is_fall || (ddr && is_rise);
            sample  <= is_rise || (ddr && is_fall);
            on_rise <= is_rise;
        end
    end

    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop) |-> (!launch && !sample));                            // R6
    AST_SDR_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ddr) |-> !(launch && sample));                             // R3
    AST_DDR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ddr) |-> (launch == sample));                               // R4

endmodule

// File: rtl/line_drive.sv
// Module: line_drive
// Maps each card line's value and drive request to pad controls.
// Push-pull passes both through. Open-drain only ever pulls low and
// releases the line for a 1.
// Assumes: purely combinational; the mode may change on any cycle.
module line_drive #(
    parameter int LINES = 5
) (
    input  logic             odrain,
    input  logic [LINES-1:0] val,
    input  logic [LINES-1:0] req,
    output logic [LINES-1:0] pad_o,
    output logic [LINES-1:0] pad_oe
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        // Select the drive style for one line.
        always_comb begin
            if (odrain) begin
                pad_o[i]  = 1'b0;
                pad_oe[i] = req[i] && !val[i];
            end else begin
                pad_o[i]  = val[i];
                pad_oe[i] = req[i];
            end
        end
    end

endmodule

// File: rtl/sd_clk_gen.sv
// Module: sd_clk_gen (top)
// Card clock generator: integer divider, SDR/DDR launch and sample strobes,
// a clock stop that parks the clock low, and open-drain or push-pull pad
// drive for the command line and the data lines.
// Assumes: nominal 100 MHz clk; synchronous active-low reset.
module sd_clk_gen
    import sd_clk_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int DAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_ddr,
    input  logic             cfg_odrain,
    input  logic             clk_stop,
    input  logic             cmd_val,
    input  logic             cmd_req,
    input  logic [DAT_W-1:0] dat_val,
    input  logic [DAT_W-1:0] dat_req,
    output logic             card_clk,
    output logic             launch_stb,
    output logic             sample_stb,
    output logic             stb_on_rise,
    output logic             cmd_pad_o,
    output logic             cmd_pad_oe,
    output logic [DAT_W-1:0] dat_pad_o,
    output logic [DAT_W-1:0] dat_pad_oe
);

    localparam int LINES = DAT_W + 1;

    clk_edge_e        edge_nxt;
    logic [LINES-1:0] pad_o_all;
    logic [LINES-1:0] pad_oe_all;

    clk_div_core #(.DIV_W(DIV_W)) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_div  (cfg_div),
        .stop     (clk_stop),
        .card_clk (card_clk),
        .edge_nxt (edge_nxt)
    );

    clk_strobe_gen i_stb (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_nxt (edge_nxt),
        .ddr      (cfg_ddr),
        .stop     (clk_stop),
        .launch   (launch_stb),
        .sample   (sample_stb),
        .on_rise  (stb_on_rise)
    );

    line_drive #(.LINES(LINES)) i_drv (
        .odrain (cfg_odrain),
        .val    ({dat_val, cmd_val}),
        .req    ({dat_req, cmd_req}),
        .pad_o  (pad_o_all),
        .pad_oe (pad_oe_all)
    );

    // Split the combined line bus back into command and data pads.
    always_comb begin
        cmd_pad_o  = pad_o_all[0];
        cmd_pad_oe = pad_oe_all[0];
        dat_pad_o  = pad_o_all[LINES-1:1];
        dat_pad_oe = pad_oe_all[LINES-1:1];
    end

    AST_RISE_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(card_clk) && !$past(clk_stop)) |-> sample_stb);            // R3
    AST_FALL_LAUNCHES: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(card_clk) && !$past(clk_stop)) |-> launch_stb);            // R3
    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_odrain |-> ((cmd_pad_o == 1'b0) && (dat_pad_o == '0)));       // R9

endmodule

// File: tb/test_sd_clk_gen.sv
module test_sd_clk_gen;

    localparam int DIV_W = 16;
    localparam int DAT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic             cfg_ddr = 1'b0;
    logic             cfg_odrain = 1'b0;
    logic             clk_stop = 1'b0;
    logic             cmd_val = 1'b0;
    logic             cmd_req = 1'b0;
    logic [DAT_W-1:0] dat_val = '0;
    logic [DAT_W-1:0] dat_req = '0;
    logic             card_clk;
    logic             launch_stb;
    logic             sample_stb;
    logic             stb_on_rise;
    logic             cmd_pad_o;
    logic             cmd_pad_oe;
    logic [DAT_W-1:0] dat_pad_o;
    logic [DAT_W-1:0] dat_pad_oe;

    int  n_chk  = 0;
    int  n_fail = 0;
    logic pc    = 1'b0;

    always #10 clk = !clk;

    sd_clk_gen #(.DIV_W(DIV_W), .DAT_W(DAT_W)) i_sd_clk_gen (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One system cycle; outputs are read 1 ns after the edge.
    task automatic tick();
        pc = card_clk;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    task automatic wait_rise();
        for (int i = 0; i < 3000; i++) begin
            tick();
            if (!pc && card_clk) return;
        end
        chk(0, "wait_rise timeout", 0, 1);
    endtask

    // Measure one full period starting right after a rise.
    task automatic measure(input bit ddr, output int cyc, output int hi,
                           output int nl, output int ns, output int bad);
        cyc = 0; hi = 0; nl = 0; ns = 0; bad = 0;
        do begin
            tick();
            cyc++;
            if (card_clk) hi++;
            if (launch_stb) nl++;
            if (sample_stb) ns++;
            if (ddr) begin
                if (launch_stb != (pc != card_clk)) bad++;
                if (sample_stb != (pc != card_clk)) bad++;
                if (launch_stb && (stb_on_rise != card_clk)) bad++;
            end else begin
                if (launch_stb != (pc && !card_clk)) bad++;
                if (sample_stb != (!pc && card_clk)) bad++;
            end
        end while (!(!pc && card_clk) && cyc < 3000);
    endtask

    task automatic t_reset();
        cfg_div = 16'd3;
        cfg_ddr = 1'b0;
        rst_n = 1'b0;
        tick();
        chk(!card_clk && !launch_stb && !sample_stb && !stb_on_rise,
            "R1 outputs in reset", {card_clk, launch_stb, sample_stb, stb_on_rise}, 0);
        tick();
        rst_n = 1'b1;
        begin
            int k = 0;
            do begin tick(); k++; end while (!card_clk && k < 100);
            chk(k == 4, "R7 edges to first rise after reset (N=3)", k, 4);
        end
    endtask

    task automatic t_sdr(input int n);
        int cyc, hi, nl, ns, bad;
        cfg_div = 16'(n);
        cfg_ddr = 1'b0;
        do_reset();
        wait_rise();
        measure(1'b0, cyc, hi, nl, ns, bad);
        chk(cyc == 2 * (n + 1), $sformatf("R2 period N=%0d", n), cyc, 2 * (n + 1));
        chk(hi == n + 1, $sformatf("R2 high half N=%0d", n), hi, n + 1);
        chk(nl == 1 && ns == 1, $sformatf("R3 SDR strobes per period N=%0d", n), nl * 10 + ns, 11);
        chk(bad == 0, $sformatf("R3 SDR strobe placement N=%0d", n), bad, 0);
    endtask

    task automatic t_ddr(input int n);
        int cyc, hi, nl, ns, bad;
        cfg_div = 16'(n);
        cfg_ddr = 1'b1;
        do_reset();
        wait_rise();
        measure(1'b1, cyc, hi, nl, ns, bad);
        chk(cyc == 2 * (n + 1), $sformatf("R2 DDR period N=%0d", n), cyc, 2 * (n + 1));
        chk(nl == 2 && ns == 2, $sformatf("R4 DDR strobes per period N=%0d", n), nl * 10 + ns, 22);
        chk(bad == 0, $sformatf("R4 DDR strobe placement/edge flag N=%0d", n), bad, 0);
        cfg_ddr = 1'b0;
    endtask

    task automatic t_change();
        int cyc, hi, nl, ns, bad;
        cfg_div = 16'd3;
        cfg_ddr = 1'b0;
        do_reset();
        wait_rise();
        cyc = 0;
        do begin
            tick();
            cyc++;
            if (cyc == 2) cfg_div = 16'd1;
        end while (!(!pc && card_clk) && cyc < 100);
        chk(cyc == 8, "R5 period in progress keeps old divider", cyc, 8);
        measure(1'b0, cyc, hi, nl, ns, bad);
        chk(cyc == 4, "R5 next period uses new divider", cyc, 4);
    endtask

    task automatic t_stop();
        int k, nstb, highs;
        cfg_div = 16'd2;
        cfg_ddr = 1'b1;
        do_reset();
        wait_rise();
        tick();
        clk_stop = 1'b1;
        k = 0; nstb = 0;
        do begin
            tick(); k++;
            if (launch_stb || sample_stb) nstb++;
        end while (card_clk && k < 50);
        chk(k == 2, "R6 high half completes before parking", k, 2);
        cfg_div = 16'd4;
        highs = 0;
        for (int i = 0; i < 20; i++) begin
            tick();
            if (card_clk) highs++;
            if (launch_stb || sample_stb) nstb++;
        end
        chk(highs == 0, "R6 clock parked low", highs, 0);
        chk(nstb == 0, "R6 no strobes while stopped", nstb, 0);
        clk_stop = 1'b0;
        k = 0;
        do begin tick(); k++; end while (!card_clk && k < 100);
        chk(k == 5, "R7 edges to first rise after release (N=4)", k, 5);
        // Stop asserted while low: the clock must not rise.
        tick();
        while (card_clk) tick();
        clk_stop = 1'b1;
        highs = 0; nstb = 0;
        for (int i = 0; i < 30; i++) begin
            tick();
            if (card_clk) highs++;
            if (launch_stb || sample_stb) nstb++;
        end
        chk(highs == 0 && nstb == 0, "R6 stop while low holds low, silent", highs + nstb, 0);
        clk_stop = 1'b0;
        cfg_ddr = 1'b0;
    endtask

    task automatic t_drive();
        int bad_pp, bad_od;
        bad_pp = 0; bad_od = 0;
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < 4; p++) begin
                cfg_odrain = m[0];
                cmd_val = p[0];
                cmd_req = p[1];
                dat_val = 4'b0101 ^ {4{p[0]}};
                dat_req = 4'b0011 ^ {4{p[1]}};
                #1;
                if (m == 0) begin
                    if (cmd_pad_o != cmd_val || cmd_pad_oe != cmd_req) bad_pp++;
                    if (dat_pad_o != dat_val || dat_pad_oe != dat_req) bad_pp++;
                end else begin
                    if (cmd_pad_o != 1'b0 || cmd_pad_oe != (cmd_req && !cmd_val)) bad_od++;
                    if (dat_pad_o != '0 || dat_pad_oe != (dat_req & ~dat_val)) bad_od++;
                end
            end
        end
        chk(bad_pp == 0, "R8 push-pull pass-through", bad_pp, 0);
        chk(bad_od == 0, "R9 open-drain release on 1", bad_od, 0);
        cfg_odrain = 1'b1; cmd_val = 1'b1; cmd_req = 1'b1;
        #1;
        chk(cmd_pad_oe == 1'b0, "R9 line requested high is released", cmd_pad_oe, 0);
        cfg_odrain = 1'b0;
        #1;
        chk(cmd_pad_oe == 1'b1 && cmd_pad_o == 1'b1, "R8 switch to push-pull drives high",
            {cmd_pad_oe, cmd_pad_o}, 3);
        cmd_req = 1'b0;
    endtask

    initial begin
        t_reset();
        t_sdr(0);
        t_sdr(1);
        t_sdr(3);
        t_sdr(499);
        t_ddr(0);
        t_ddr(2);
        t_change();
        t_stop();
        t_drive();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all) actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule